// File: doc/BRIEF.md
# Single-Bit Daisy-Chain Pixel Node

This block is one link in a chain of on/off LED nodes that all hang off a single serial wire. The controller sends a train of high pulses, and the width of each pulse carries one bit: a narrow pulse turns the LED off and a wide pulse turns it on. Each node keeps the first valid pulse of a frame for itself and passes every later pulse on its serial output to the next node. In this way the first node takes bit 0, the second takes bit 1, and so on. A quiet line lasting longer than the idle timeout closes the frame, and every node is then ready to take a fresh bit.

The input is brought into the clock domain through a flop synchroniser, and the node then detects its edges. The node decides the bit by a race between two events. One is the falling edge of the data. The other is the end of a fixed measuring window that starts on the rising edge and cannot be restarted. The LED register takes the result the moment the race is decided. It does not wait for the end of the frame.

The controller is a four-state machine:
- `ST_RECV`: idle, waiting for a rising edge. On a rising edge it moves to `ST_MEAS`.
- `ST_MEAS`: the window is running.
  - A falling edge before the window ends sends it to `ST_FWD` with the LED off.
  - If that pulse was a glitch, it goes back to `ST_RECV` instead.
  - If the window runs out while the input is still high, it moves to `ST_HOLD` with the LED on.
- `ST_HOLD`: the bit is decided and the node waits for the pulse to end. The falling edge moves it to `ST_FWD`.
- `ST_FWD`: pulses are passed through. On timeout it returns to `ST_RECV`, or goes to `ST_MEAS` if a rising edge arrives in that same cycle.

Top module: `bitpix_node`

## Requirements
- R1: A synchronous active-high reset puts the node in the receiving state. It drives `led` to 0 and `dout` to 0 and clears the idle timer.
- R2: Widths are counted in synchronised high samples. In the receiving state, a first pulse whose width is between GLITCH_CYC+1 and WIN_CYC-1 drives `led` to 0. `led` changes on the third clock edge after the last high sample, and forwarding starts at that point.
- R3: A first pulse with at least WIN_CYC high samples drives `led` to 1 on the second edge after its WIN_CYC-th high sample, while the input is still high. The window is not restarted by the rest of the pulse.
- R4: A pulse of GLITCH_CYC or fewer high samples in the receiving state leaves `led` unchanged. The node stays in the receiving state, so the next pulse is still decoded locally.
- R5: After the first pulse ends, every later pulse appears on `dout` with the same width, two clock edges after each input sample. `led` does not change while forwarding.
- R6: `dout` is held low whenever the node is not forwarding, which includes the whole of the locally decoded pulse.
- R7: While forwarding, each falling edge on the input restarts the idle timer. After IDLE_CYC clock edges with no falling edge, the node returns to the receiving state. In terms of the input, a rising edge that follows IDLE_CYC-1 low samples is still forwarded.
- R8: A rising edge that arrives in the exact cycle the idle timeout expires is decoded locally and not forwarded. In terms of the input, this is a pulse that follows exactly IDLE_CYC low samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Node clock |
| rst  | input  | 1 | Synchronous active-high reset |
| din  | input  | 1 | Serial pulse input from the previous node, asynchronous |
| dout | output | 1 | Serial pulse output to the next node, registered |
| led  | output | 1 | LED drive, 1 = on |

## Verification
A wrong internal state shows up at the ports within one frame.

- A node stuck in forwarding never changes `led` again.
- A node stuck in receiving swallows a second pulse, so the next node sees one pulse too few on `dout`.
- An idle timer that is off by one cycle moves the pulse that lands right at the timeout boundary from `dout` to `led`, or the other way round.

The bench compares both outputs against its behavioural model on every clock. It therefore catches each of these faults within a few cycles of the pulse edge that exposes it.

// File: rtl/bitpix_pkg.sv
package bitpix_pkg;
    typedef enum logic [1:0] {
        ST_RECV = 2'd0,
        ST_MEAS = 2'd1,
        ST_HOLD = 2'd2,
        ST_FWD  = 2'd3
    } bitpix_state_e;
endpackage

// File: rtl/bitpix_sync.sv
module bitpix_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            last <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            last <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~last;
    assign fall = ~pipe[STAGES-1] & last;
endmodule

// File: rtl/bitpix_width.sv
module bitpix_width #(
    parameter int WIN_CYC    = 10,
    parameter int GLITCH_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    input  logic lvl,
    output logic long_hit,
    output logic above_glitch
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(1);
        else if (run && lvl)
            cnt <= cnt + CW'(1);
    end

    assign long_hit     = run && lvl && (cnt == CW'(WIN_CYC - 1));
    assign above_glitch = (cnt > CW'(GLITCH_CYC));
endmodule

// File: rtl/bitpix_idle.sv
module bitpix_idle #(
    parameter int IDLE_CYC = 320
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int TW = $clog2(IDLE_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick)
            cnt <= '0;
        else
            cnt <= cnt + TW'(1);
    end

    assign expire = run && !kick && (cnt == TW'(IDLE_CYC - 1));
endmodule

// File: rtl/bitpix_node.sv
module bitpix_node
    import bitpix_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYC     = 10,
    parameter int GLITCH_CYC  = 1,
    parameter int IDLE_CYC    = 320
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic led
);
    bitpix_state_e state_q, state_n;
    logic lvl_s, rise_s, fall_s;
    logic long_hit, above_glitch, expire;
    logic led_q, led_n, dout_q;
    logic win_start;

    bitpix_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (din),
        .lvl (lvl_s),
        .rise(rise_s),
        .fall(fall_s)
    );

    assign win_start = rise_s && ((state_q == ST_RECV) || expire);

    bitpix_width #(.WIN_CYC(WIN_CYC), .GLITCH_CYC(GLITCH_CYC)) u_width (
        .clk         (clk),
        .rst         (rst),
        .start       (win_start),
        .run         (state_q == ST_MEAS),
        .lvl         (lvl_s),
        .long_hit    (long_hit),
        .above_glitch(above_glitch)
    );

    bitpix_idle #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk   (clk),
        .rst   (rst),
        .run   (state_q == ST_FWD),
        .kick  (fall_s),
        .expire(expire)
    );

    // next-state and decision logic
    always_comb begin
        state_n = state_q;
        led_n   = led_q;
        unique case (state_q)
            ST_RECV: if (rise_s) state_n = ST_MEAS;
            ST_MEAS: begin
                if (fall_s) begin
                    if (above_glitch) begin
                        led_n   = 1'b0;
                        state_n = ST_FWD;
                    end else begin
                        state_n = ST_RECV;
                    end
                end else if (long_hit) begin
                    led_n   = 1'b1;
                    state_n = ST_HOLD;
                end
            end
            ST_HOLD: if (fall_s) state_n = ST_FWD;
            ST_FWD:  if (expire) state_n = rise_s ? ST_MEAS : ST_RECV;
            default: state_n = ST_RECV;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_RECV;
        else
            state_q <= state_n;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            led_q  <= led_n;
            dout_q <= (state_q == ST_FWD) && !expire && lvl_s;
        end
    end

    assign led  = led_q;
    assign dout = dout_q;
endmodule

// File: rtl/bitpix_node_chk.sv
module bitpix_node_chk
    import bitpix_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          led,
    input logic          dout,
    input bitpix_state_e state,
    input logic          lvl,
    input logic          fall
);
    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            // R1
            reset_state_chk: assert (!led && !dout && state == ST_RECV)
                else $error("reset state wrong");
        end
    end

    // R6
    fwd_only_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FWD) |=> !dout);

    // R5
    led_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_MEAS) |=> $stable(led));

    // R3
    hold_on_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> led);

    // R7
    retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FWD && fall) |=> (state == ST_FWD));

    // R2
    meas_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MEAS && !lvl) |=> (state != ST_MEAS));
endmodule

bind bitpix_node bitpix_node_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .led  (led),
    .dout (dout),
    .state(state_q),
    .lvl  (lvl_s),
    .fall (fall_s)
);

// File: tb/test_bitpix_node.sv
module test_bitpix_node;
    localparam int WIN  = 10;
    localparam int GLT  = 1;
    localparam int IDLE = 320;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout, led;

    int vectors = 0;
    int miscompares = 0;
    int n_fwd = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bitpix_node i_bitpix_node (
        .clk (clk),
        .rst (rst),
        .din (din),
        .dout(dout),
        .led (led)
    );

    // behavioural reference
    bit h_prev, h_s2, h_s1;
    bit taken, measuring, decided;
    int width, quiet;
    bit m_led, m_dout;

    always @(posedge clk) begin
        bit s, p, rise, fall, tout;
        if (rst) begin
            taken = 0; measuring = 0; decided = 0; width = 0; quiet = 0;
            m_led = 0; m_dout = 0;
            h_prev = 0; h_s2 = 0; h_s1 = 0;
        end else begin
            s = h_s2; p = h_prev;
            rise = s && !p;
            fall = !s && p;
            tout = taken && !fall && (quiet == IDLE - 1);
            m_dout = taken && !tout && s;
            if (taken) begin
                if (tout) begin
                    taken = 0; quiet = 0;
                    if (rise) begin measuring = 1; width = 1; decided = 0; end
                end else if (fall) quiet = 0;
                else quiet++;
            end else if (measuring) begin
                if (fall) begin
                    measuring = 0;
                    if (decided) begin taken = 1; quiet = 0; end
                    else if (width > GLT) begin m_led = 0; taken = 1; quiet = 0; end
                end else if (!decided) begin
                    width++;
                    if (width == WIN) begin m_led = 1; decided = 1; end
                end
            end else if (rise) begin
                measuring = 1; width = 1; decided = 0;
            end
            h_prev = h_s2; h_s2 = h_s1; h_s1 = din;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors += 2;
            if (led !== m_led) begin
                miscompares++;
                $display("FAIL R3 led model mismatch at %0t: actual %b expected %b", $time, led, m_led);
            end
            if (dout !== m_dout) begin
                miscompares++;
                $display("FAIL R5 dout model mismatch at %0t: actual %b expected %b", $time, dout, m_dout);
            end
            if (dout && !dout_prev) n_fwd++;
        end
        dout_prev = dout;
    end
    bit dout_prev = 0;

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        vectors++;
        if (!cond) begin
            miscompares++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        din = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        din = 1'b1;
        repeat (hi) @(negedge clk);
        din = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(led == 0, "R1 led after reset", led, 0);
        chk(dout == 0, "R1 dout after reset", dout, 0);

        // long first pulse, then three forwarded pulses
        pulse(15, 5);
        chk(led == 1, "R3 long pulse sets led", led, 1);
        n_fwd = 0;
        pulse(4, 5); pulse(12, 5); pulse(3, 5); idle(5);
        chk(n_fwd == 3, "R5 forwarded pulse count", n_fwd, 3);
        chk(led == 1, "R5 led unchanged while forwarding", led, 1);
        idle(IDLE + 20);

        // short first pulse
        n_fwd = 0;
        pulse(5, 6);
        chk(led == 0, "R2 short pulse clears led", led, 0);
        chk(n_fwd == 0, "R6 first pulse not forwarded", n_fwd, 0);
        pulse(20, 6);
        chk(led == 0, "R5 long forwarded pulse keeps led", led, 0);
        chk(n_fwd == 1, "R5 one forwarded pulse", n_fwd, 1);
        idle(IDLE + 20);

        // glitch ignored, next pulse still local
        n_fwd = 0;
        pulse(1, 8);
        chk(led == 0, "R4 glitch leaves led", led, 0);
        pulse(12, 6);
        chk(led == 1, "R4 pulse after glitch decoded", led, 1);
        chk(n_fwd == 0, "R4 nothing forwarded", n_fwd, 0);
        idle(IDLE + 20);

        // window boundaries
        pulse(WIN - 1, 6);
        chk(led == 0, "R2 width WIN-1 is off", led, 0);
        idle(IDLE + 20);
        pulse(WIN, 6);
        chk(led == 1, "R3 width WIN is on", led, 1);
        idle(IDLE + 20);
        pulse(GLT + 1, 6);
        chk(led == 0, "R2 minimum width is off", led, 0);
        idle(IDLE + 20);

        // decision before the falling edge
        din = 1'b1;
        repeat (WIN + 3) @(negedge clk);
        chk(led == 1, "R3 led on while input high", led, 1);
        din = 1'b0;
        idle(IDLE + 20);

        // retrigger keeps forwarding
        pulse(3, 4);
        n_fwd = 0;
        pulse(4, IDLE - 20);
        pulse(4, IDLE - 20);
        pulse(4, 4);
        chk(n_fwd == 3, "R7 retriggered forwarding", n_fwd, 3);
        chk(led == 0, "R7 led untouched while forwarding", led, 0);
        idle(IDLE + 10);
        pulse(12, 6);
        chk(led == 1, "R7 decoded after timeout", led, 1);
        idle(IDLE + 20);

        // timeout boundary: IDLE-1 low samples still forwards
        pulse(5, IDLE - 1);
        n_fwd = 0;
        pulse(12, 6);
        chk(n_fwd == 1, "R7 pulse before timeout forwarded", n_fwd, 1);
        chk(led == 0, "R7 led kept at boundary", led, 0);
        idle(IDLE + 20);

        // exactly IDLE low samples: rise on expiry cycle decoded locally
        pulse(5, 2);
        idle(IDLE - 2);
        n_fwd = 0;
        pulse(12, 6);
        chk(n_fwd == 0, "R8 expiry-cycle pulse not forwarded", n_fwd, 0);
        chk(led == 1, "R8 expiry-cycle pulse decoded", led, 1);
        idle(IDLE + 20);

        // reset while forwarding
        pulse(12, 4);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(led == 0, "R1 reset clears led", led, 0);
        chk(dout == 0, "R1 reset clears dout", dout, 0);
        pulse(12, 6);
        chk(led == 1, "R1 receiving after reset", led, 1);
        idle(10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule